// File: doc/BRIEF.md
# Serial-Programmed Video Crosspoint Configuration Slave

This block is the control side of an eight-source, six-destination video routing matrix. It listens on a two-wire serial bus (I2C Standard mode, write-only), oversampling the clock and data lines with the system clock. After a start condition it compares the first byte with its own device address. The upper two bits of that address come from two strap pins. If the address matches, it accepts a register-pointer byte and then any number of data bytes, and it acknowledges every byte by pulling the data line low.

The register bank it writes drives the analog matrix directly. For each destination it provides a 4-bit source select, an enable and a gain bit. For each source it provides a clamp/bias choice. Two destinations share each select register. A select code of zero turns a destination off. Several destinations may take the same source. The analog path itself lies outside this block.

Top module: `xbar_cfg_slave`

## Requirements
- R1: After synchronous reset, every select code, enable, clamp bit and gain bit is 0, and the data line is released (`sda_pull_low` = 0).
- R2: The slave acknowledges an address byte exactly equal to {strap[1], strap[0], 6'b000110}. This gives 0x06, 0x46, 0x86 or 0xC6 for straps 00, 01, 10 and 11. It acknowledges by holding SDA low during the high phase of the ninth clock.
- R3: An address byte that does not match, or that has bit 0 (read/write) set to 1, is not acknowledged. The bytes that follow it are neither acknowledged nor written until the next start or stop.
- R4: The byte after the address is the register pointer. Each later data byte is written to the pointer address, and the pointer then increments by one. Register values change only on such a write.
- R5: Registers 0x00, 0x01 and 0x02 each hold two select fields. Bits 3:0 route output 2k+1 and bits 7:4 route output 2k+2, for k = 0, 1, 2. Codes 1 to 8 name inputs 1 to 8, and any number of outputs may carry the same code.
- R6: An output whose select code is 0000 has its enable at 0. Any other code sets its enable to 1.
- R7: Register 0x03 bit i sets the clamp/bias choice of input i+1 (1 = clamp, 0 = bias).
- R8: Register 0x04 bits 5:0 set the gain of outputs 1 to 6 (1 = 0 dB, 0 = 6 dB). Bits 7:6 are ignored.
- R9: A data byte whose pointer is 0x05 or higher is acknowledged and changes no output.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts address matching. Bytes clocked after a STOP with no new START are ignored and not acknowledged.
- R11: A pulse on SCL or SDA shorter than three system clocks is filtered out and does not shift a bit.
- R12: The slave pulls SDA low only while SCL is low. It starts after the eighth clock falls and releases after the ninth clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as sensed |
| sda_in | input | 1 | Serial data line as sensed |
| strap | input | 2 | Address strap pins, become address bits 7:6 |
| sda_pull_low | output | 1 | Open-drain pull-down enable for SDA |
| route_sel | output | 24 | Select code per output, output k at bits 4k+3:4k |
| out_en | output | 6 | Enable per output |
| gain_unity | output | 6 | Gain bit per output, 1 = 0 dB |
| clamp_mode | output | 8 | Clamp (1) or bias (0) per input |

## Verification
On every cycle the assertions check four things. Each enable agrees with whether its select code is zero. The configuration holds still unless a write strobe occurred. The pull-down only rises or falls while SCL is low. Reset clears every output. Only the bench scenarios can show the rest: address matching under each strap value, refusal of wrong addresses and reads, pointer auto-increment across the whole map, silent acceptance of unmapped pointers, repeated-start recovery, bytes after a stop being ignored, and rejection of a short SCL glitch.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } bus_state_t;
endpackage

// File: rtl/xcfg_deglitch.sv
module xcfg_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  // A new level is accepted only after it has persisted FILT_CYC clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      clean <= 1'b1;
      run_q <= '0;
    end else if (sync_q[SYNC_STAGES-1] == clean) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_CYC - 1)) begin
      clean <= sync_q[SYNC_STAGES-1];
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/xcfg_bus_engine.sv
module xcfg_bus_engine
  import xcfg_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter logic [5:0] DEV_LOW  = 6'b000110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic [1:0]        strap,
  output logic              pull_low,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int BCW = $clog2(BYTE_W + 1);

  bus_state_t        st_q, after_ack_q;
  logic              scl_q, sda_q;
  logic [BCW-1:0]    nbits_q;
  logic [BYTE_W-1:0] shreg_q, ptr_q;
  logic [BYTE_W-1:0] own_addr;

  logic scl_rise, scl_fall, cond_start, cond_stop, byte_done;

  assign own_addr   = {strap, DEV_LOW};
  assign scl_rise   = scl & ~scl_q;
  assign scl_fall   = ~scl & scl_q;
  assign cond_start = scl & scl_q & sda_q & ~sda;
  assign cond_stop  = scl & scl_q & ~sda_q & sda;
  assign byte_done  = scl_fall && (nbits_q == BCW'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      after_ack_q <= ST_IDLE;
      nbits_q     <= '0;
      shreg_q     <= '0;
      ptr_q       <= '0;
      pull_low    <= 1'b0;
      wr_stb      <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (cond_start) begin
        st_q     <= ST_ADDR;
        nbits_q  <= '0;
        pull_low <= 1'b0;
      end else if (cond_stop) begin
        st_q     <= ST_IDLE;
        pull_low <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_PTR, ST_DATA: begin
            if (scl_rise && nbits_q < BCW'(BYTE_W)) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda};
              nbits_q <= nbits_q + 1'b1;
            end else if (byte_done) begin
              nbits_q <= '0;
              if (st_q == ST_ADDR) begin
                if (shreg_q == own_addr) begin
                  pull_low    <= 1'b1;
                  st_q        <= ST_ACK;
                  after_ack_q <= ST_PTR;
                end else begin
                  st_q <= ST_SKIP;
                end
              end else if (st_q == ST_PTR) begin
                ptr_q       <= shreg_q;
                pull_low    <= 1'b1;
                st_q        <= ST_ACK;
                after_ack_q <= ST_DATA;
              end else begin
                wr_stb      <= 1'b1;
                wr_addr     <= ptr_q;
                wr_data     <= shreg_q;
                ptr_q       <= ptr_q + 1'b1;
                pull_low    <= 1'b1;
                st_q        <= ST_ACK;
                after_ack_q <= ST_DATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              pull_low <= 1'b0;
              st_q     <= after_ack_q;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xcfg_reg_bank.sv
module xcfg_reg_bank #(
  parameter int BYTE_W = 8,
  parameter int N_IN   = 8,
  parameter int N_OUT  = 6,
  parameter int SEL_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [BYTE_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [N_OUT*SEL_W-1:0] route_sel,
  output logic [N_OUT-1:0]       out_en,
  output logic [N_OUT-1:0]       gain_unity,
  output logic [N_IN-1:0]        clamp_mode
);
  localparam int PER_REG   = BYTE_W / SEL_W;
  localparam int N_SEL_REG = (N_OUT + PER_REG - 1) / PER_REG;
  localparam int CLAMP_IDX = N_SEL_REG;
  localparam int GAIN_IDX  = N_SEL_REG + 1;

  always_ff @(posedge clk) begin
    if (rst)                                             clamp_mode <= '0;
    else if (wr_stb && wr_addr == BYTE_W'(CLAMP_IDX))    clamp_mode <= wr_data[N_IN-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                                             gain_unity <= '0;
    else if (wr_stb && wr_addr == BYTE_W'(GAIN_IDX))     gain_unity <= wr_data[N_OUT-1:0];
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int REG = o / PER_REG;
    localparam int LSB = (o % PER_REG) * SEL_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        route_sel[o*SEL_W +: SEL_W] <= '0;
        out_en[o]                   <= 1'b0;
      end else if (wr_stb && wr_addr == BYTE_W'(REG)) begin
        route_sel[o*SEL_W +: SEL_W] <= wr_data[LSB +: SEL_W];
        out_en[o]                   <= |wr_data[LSB +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/xbar_cfg_slave.sv
module xbar_cfg_slave #(
  parameter int         BYTE_W   = 8,
  parameter int         N_IN     = 8,
  parameter int         N_OUT    = 6,
  parameter int         SEL_W    = 4,
  parameter int         FILT_CYC = 3,
  parameter logic [5:0] DEV_LOW  = 6'b000110
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_in,
  input  logic                   sda_in,
  input  logic [1:0]             strap,
  output logic                   sda_pull_low,
  output logic [N_OUT*SEL_W-1:0] route_sel,
  output logic [N_OUT-1:0]       out_en,
  output logic [N_OUT-1:0]       gain_unity,
  output logic [N_IN-1:0]        clamp_mode
);
  logic              scl_f, sda_f;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  xcfg_deglitch #(.SYNC_STAGES(2), .FILT_CYC(FILT_CYC)) u_scl_flt (
    .clk(clk), .rst(rst), .raw(scl_in), .clean(scl_f)
  );
  xcfg_deglitch #(.SYNC_STAGES(2), .FILT_CYC(FILT_CYC)) u_sda_flt (
    .clk(clk), .rst(rst), .raw(sda_in), .clean(sda_f)
  );

  xcfg_bus_engine #(.BYTE_W(BYTE_W), .DEV_LOW(DEV_LOW)) u_engine (
    .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f), .strap(strap),
    .pull_low(sda_pull_low), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  xcfg_reg_bank #(.BYTE_W(BYTE_W), .N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .route_sel(route_sel), .out_en(out_en), .gain_unity(gain_unity), .clamp_mode(clamp_mode)
  );
endmodule

// File: rtl/xcfg_checker.sv
module xcfg_checker #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 6,
  parameter int SEL_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_f,
  input logic                   pull_low,
  input logic                   wr_stb,
  input logic [N_OUT*SEL_W-1:0] route_sel,
  input logic [N_OUT-1:0]       out_en,
  input logic [N_OUT-1:0]       gain_unity,
  input logic [N_IN-1:0]        clamp_mode
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (route_sel == '0 && out_en == '0 && gain_unity == '0 && clamp_mode == '0 && !pull_low));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable({route_sel, out_en, gain_unity, clamp_mode}));

  for (genvar o = 0; o < N_OUT; o++) begin : g_en
    p_en_vs_code_r6: assert property (@(posedge clk) disable iff (rst)
      out_en[o] == (route_sel[o*SEL_W +: SEL_W] != '0));
  end

  p_pull_start_low_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_low) |-> !scl_f);

  p_pull_end_low_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_low) |-> !scl_f);
endmodule

bind xbar_cfg_slave xcfg_checker #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .pull_low(sda_pull_low), .wr_stb(wr_stb),
  .route_sel(route_sel), .out_en(out_en), .gain_unity(gain_unity), .clamp_mode(clamp_mode)
);

// File: tb/xbar_cfg_slave_tb.sv
module xbar_cfg_slave_tb;
  localparam int H = 16;

  logic clk = 0, rst = 1;
  logic scl_m = 1, sda_m = 1;
  logic [1:0] strap = 2'b00;
  logic sda_pull_low;
  logic [23:0] route_sel;
  logic [5:0] out_en, gain_unity;
  logic [7:0] clamp_mode;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull_low;

  xbar_cfg_slave u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .strap(strap),
    .sda_pull_low(sda_pull_low), .route_sel(route_sel), .out_en(out_en),
    .gain_unity(gain_unity), .clamp_mode(clamp_mode)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_en = 0;
  int m_sel[6];
  int m_clamp = 0, m_gain = 0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_write(int a, int d);
    if (a <= 2) begin
      m_sel[2*a]   = d & 15;
      m_sel[2*a+1] = (d >> 4) & 15;
    end else if (a == 3) m_clamp = d;
    else if (a == 4) m_gain = d & 63;
  endfunction

  function automatic bit model_match();
    for (int o = 0; o < 6; o++) begin
      if (route_sel[o*4 +: 4] != 4'(m_sel[o])) return 0;
      if (out_en[o] != (m_sel[o] != 0)) return 0;
    end
    return clamp_mode == 8'(m_clamp) && gain_unity == 6'(m_gain);
  endfunction

  // Per-clock comparison against the behavioural model while the bus is quiet.
  always @(negedge clk) begin
    cyc++;
    if (cmp_en) check(model_match(), "R4 model", int'(route_sel), m_sel[0]);
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    cmp_en = 0;
    sda_m = 1; waitc(H); scl_m = 1; waitc(H);
    sda_m = 0; waitc(H); scl_m = 0; waitc(H);
  endtask

  task automatic do_stop();
    sda_m = 0; waitc(H); scl_m = 1; waitc(H); sda_m = 1; waitc(4*H);
    cmp_en = 1;
  endtask

  // Sends one byte MSB first; glitch inserts a 2-cycle SCL low pulse mid bit 3.
  task automatic send_byte(int b, bit exp_ack, string req, bit glitch = 0);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(H); scl_m = 1;
      if (glitch && i == 3) begin
        waitc(H/2); scl_m = 0; waitc(2); scl_m = 1; waitc(H/2 - 2);
      end else waitc(H);
      scl_m = 0;
    end
    sda_m = 1; waitc(H); scl_m = 1; waitc(H/2);
    got = !sda_line;
    check(got == exp_ack, req, got, exp_ack);
    waitc(H/2); scl_m = 0; waitc(12);
    check(sda_pull_low == 0, "R12 release", sda_pull_low, 0);
  endtask

  task automatic write_txn(int adr, int ptr, int data[$], bit acked, string req);
    do_start();
    send_byte(adr, acked, req);
    send_byte(ptr, acked, req);
    for (int i = 0; i < data.size(); i++) begin
      send_byte(data[i], acked, req);
      if (acked) model_write(ptr + i, data[i]);
    end
    do_stop();
  endtask

  initial begin
    for (int o = 0; o < 6; o++) m_sel[o] = 0;
    waitc(5); rst = 0; waitc(3);
    // R1 reset state
    check(route_sel == 0 && out_en == 0, "R1 routes", int'(route_sel), 0);
    check(clamp_mode == 0 && gain_unity == 0, "R1 clamp/gain", int'(clamp_mode), 0);
    check(sda_pull_low == 0, "R1 sda", sda_pull_low, 0);
    cmp_en = 1;

    // R2 / R5 basic write with strap 00
    write_txn(8'h06, 0, '{8'h21}, 1, "R2 addr 0x06");
    check(route_sel[3:0] == 1 && route_sel[7:4] == 2, "R5 out1/out2", int'(route_sel[7:0]), 8'h21);
    // R4 burst across select, clamp and gain; R7, R8
    write_txn(8'h06, 1, '{8'h43, 8'h85, 8'hA5, 8'hFF}, 1, "R4 burst");
    check(clamp_mode == 8'hA5, "R7 clamp", clamp_mode, 8'hA5);
    check(gain_unity == 6'h3F, "R8 gain bits 7:6 ignored", gain_unity, 6'h3F);
    check(route_sel[23:8] == 16'h8543, "R4 increment", int'(route_sel[23:8]), 16'h8543);
    // R9 unmapped pointer, also burst running off the map
    write_txn(8'h06, 8'h07, '{8'h55, 8'h66}, 1, "R9 unmapped ack");
    write_txn(8'h06, 4, '{8'h0A, 8'h99}, 1, "R9 burst past end");
    check(gain_unity == 6'h0A, "R8 gain", gain_unity, 6'h0A);
    // R6 code 0 is off; R5 one-to-many
    write_txn(8'h06, 0, '{8'h10, 8'h11}, 1, "R6 off code");
    check(out_en[0] == 0 && out_en[1] == 1, "R6 enable", out_en, 6'h3E);
    check(route_sel[15:8] == 8'h11, "R5 one-to-many", int'(route_sel[15:8]), 8'h11);

    // R2 other straps; R3 mismatch and read
    strap = 2'b10; waitc(10);
    write_txn(8'h86, 2, '{8'h37}, 1, "R2 addr 0x86");
    write_txn(8'h06, 2, '{8'h00}, 0, "R3 stale addr nack");
    write_txn(8'h87, 2, '{8'h00}, 0, "R3 read nack");
    check(route_sel[23:16] == 8'h37, "R3 no write", int'(route_sel[23:16]), 8'h37);
    strap = 2'b01; waitc(10);
    write_txn(8'h46, 3, '{8'h5A}, 1, "R2 addr 0x46");
    strap = 2'b11; waitc(10);
    write_txn(8'hC6, 3, '{8'h3C}, 1, "R2 addr 0xC6");
    check(clamp_mode == 8'h3C, "R7 clamp 0xC6", clamp_mode, 8'h3C);

    // R10 repeated start after a refused address
    do_start();
    send_byte(8'h06, 0, "R10 wrong addr");
    send_byte(8'h00, 0, "R10 ignored byte");
    sda_m = 1; waitc(H); scl_m = 1; waitc(H); sda_m = 0; waitc(H); scl_m = 0; waitc(H);
    send_byte(8'hC6, 1, "R10 restart addr");
    send_byte(8'h00, 1, "R10 restart ptr");
    send_byte(8'h68, 1, "R10 restart data"); model_write(0, 8'h68);
    do_stop();
    check(route_sel[7:0] == 8'h68, "R10 restart write", int'(route_sel[7:0]), 8'h68);
    // R10 bytes after stop without start ignored
    cmp_en = 0;
    send_byte(8'hC6, 0, "R10 after stop");
    send_byte(8'h00, 0, "R10 after stop");
    sda_m = 1; waitc(4*H); cmp_en = 1;

    // R11 short SCL glitch does not add a bit
    do_start();
    send_byte(8'hC6, 1, "R11 addr");
    send_byte(8'h01, 1, "R11 ptr");
    send_byte(8'h72, 1, "R11 glitch byte", 1); model_write(1, 8'h72);
    do_stop();
    check(route_sel[15:8] == 8'h72, "R11 glitch ignored", int'(route_sel[15:8]), 8'h72);

    waitc(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule